// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between a MAC's transmit-enable strobe and the line driver and stops a transmitter that stays on for too long. While a transmission is shorter than a programmable limit, the block passes transmit and loopback permission through unchanged. If the MAC is still driving when the limit runs out, the block latches into a jabber condition. In that condition it removes transmit and loopback permission and asks the MAC to report a collision.

Leaving the jabber condition needs an unbroken quiet period on the transmit-enable input. Any activity during that period sends the block back to the latched state. The next quiet period then has to run its full length again. Both time limits are counted in pulses of a shared timebase tick, so a system can set them to tens or hundreds of milliseconds and a simulation can set them to a few ticks.

The state machine has four states: idle, transmitting, jabbing and waiting-to-unjab. Power-on is folded into the synchronous reset, which places the block in idle. Two tick counters supply the limits: one runs only while transmitting, the other only while waiting to unjab.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset, with no transmit activity, `tx_allow` and `lpbk_allow` are 1 and `col_req` and `jabbering` are 0.
- R2: A transmission that drops `tx_active` before the jab decision returns the block to idle. `col_req` never rises on this path. This holds even on the very edge where the tick count has just reached `MAX_XMIT_TICKS`.
- R3: The transmit timer advances only on clock edges that see `tick` high while the block is transmitting. A transmission with no ticks never jabs, however long it lasts.
- R4: The transmit timer starts at zero on the edge that leaves idle. Once it has counted `MAX_XMIT_TICKS` ticks, a later edge that still sees `tx_active` high enters jab. From the next cycle on, `tx_allow` and `lpbk_allow` are 0 and `col_req` and `jabbering` are 1.
- R5: While jabbing, the block stays jabbing as long as `tx_active` remains high.
- R6: An edge in jab that sees `tx_active` low moves the block to waiting-to-unjab. All four outputs keep their jabbing values.
- R7: While waiting to unjab, an edge that sees `tx_active` high returns the block to jab. The next quiet period again needs the full `UNJAB_TICKS` ticks.
- R8: While waiting to unjab with `tx_active` low, the unjab timer counts ticks from zero. Once it has reached `UNJAB_TICKS`, the next edge returns the block to idle. A following transmission then gets a fresh, full transmit timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse that both timers count |
| tx_active | input | 1 | Transmit data output is active (from the MAC) |
| tx_allow | output | 1 | Transmit path enabled |
| lpbk_allow | output | 1 | Loopback path enabled |
| col_req | output | 1 | Collision/SQE indication request to the MAC |
| jabbering | output | 1 | High in jab and in waiting-to-unjab |

## Verification
The bench aims at the edge where the transmit count has just reached its limit. It drops `tx_active` on exactly that edge, where a design with an off-by-one compare would jab early or would never recover. It re-asserts activity partway through the unjab window. A design that did not restart the window would release the transmitter too soon. It drives long transmissions with the tick held low, and sparse ticks, to catch a timer that counts clocks instead of ticks. After unjab it sends a normal frame, which exposes a transmit counter that was never cleared.

// File: rtl/jg_pkg.sv
// Package: shared state encoding for the transmit jabber watchdog.
// Assumes: two-bit encoding; power-on is folded into the reset state.
package jg_pkg;
    typedef enum logic [1:0] {
        JG_IDLE  = 2'd0,
        JG_XMIT  = 2'd1,
        JG_JAB   = 2'd2,
        JG_UNJAB = 2'd3
    } jg_state_t;
endpackage

// File: rtl/jg_tick_timer.sv
// Module: saturating counter of timebase ticks with a synchronous clear.
// Assumes: clear has priority over tick; done stays high while the count
// sits at LIMIT until the next clear.
module jg_tick_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count ticks up to LIMIT, restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    // Terminal count reached.
    assign done = (cnt == LIM);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/jg_fsm.sv
// Module: four-state jabber control machine.
// Assumes: the timer done flags come from counters cleared whenever the
// machine is outside the state that owns them.
module jg_fsm
    import jg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_active,
    input  logic      xmit_done,
    input  logic      unjab_done,
    output jg_state_t state,
    output logic      tx_allow,
    output logic      lpbk_allow,
    output logic      col_req,
    output logic      jabbering
);
    jg_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            JG_IDLE:  if (tx_active) nxt = JG_XMIT;
            JG_XMIT:  if (!tx_active) nxt = JG_IDLE;
                      else if (xmit_done) nxt = JG_JAB;
            JG_JAB:   if (!tx_active) nxt = JG_UNJAB;
            JG_UNJAB: if (tx_active) nxt = JG_JAB;
                      else if (unjab_done) nxt = JG_IDLE;
            default:  nxt = JG_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= JG_IDLE;
        else        state <= nxt;
    end

    // Output decode from the registered state.
    always_comb begin
        jabbering  = (state == JG_JAB) || (state == JG_UNJAB);
        tx_allow   = !jabbering;
        lpbk_allow = !jabbering;
        col_req    = jabbering;
    end

    // R2
    short_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_XMIT && !tx_active) |=> (state == JG_IDLE && !col_req));

    // R4
    jab_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_XMIT && tx_active && xmit_done) |=> (state == JG_JAB));

    // R5
    jab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_JAB && tx_active) |=> (state == JG_JAB));

    // R6
    unjab_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_JAB && !tx_active) |=> (state == JG_UNJAB && jabbering));

    // R7
    unjab_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_UNJAB && tx_active) |=> (state == JG_JAB));

    // R8
    unjab_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == JG_UNJAB && !tx_active && !unjab_done) |=> (state == JG_UNJAB));
endmodule

// File: rtl/tx_jabber_guard.sv
// Module: transmit jabber watchdog top. Counts timebase ticks while the
// MAC transmits and latches a jabber condition past MAX_XMIT_TICKS. It
// releases only after UNJAB_TICKS ticks of continuous transmit idle.
// Assumes: tick is a single-cycle pulse, synchronous to clk.
module tx_jabber_guard #(
    parameter int MAX_XMIT_TICKS = 100,
    parameter int UNJAB_TICKS    = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_active,
    output logic tx_allow,
    output logic lpbk_allow,
    output logic col_req,
    output logic jabbering
);
    import jg_pkg::*;

    jg_state_t state;
    logic      xmit_done;
    logic      unjab_done;
    logic      xmit_clr;
    logic      unjab_clr;

    // Each timer runs only in the state that owns it.
    assign xmit_clr  = (state != JG_XMIT);
    assign unjab_clr = (state != JG_UNJAB);

    jg_tick_timer #(.LIMIT(MAX_XMIT_TICKS)) xmit_tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(xmit_clr), .tick(tick), .done(xmit_done)
    );

    jg_tick_timer #(.LIMIT(UNJAB_TICKS)) unjab_tmr_i (
        .clk(clk), .rst_n(rst_n), .clear(unjab_clr), .tick(tick), .done(unjab_done)
    );

    jg_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
        .xmit_done(xmit_done), .unjab_done(unjab_done), .state(state),
        .tx_allow(tx_allow), .lpbk_allow(lpbk_allow),
        .col_req(col_req), .jabbering(jabbering)
    );
endmodule

// File: tb/tx_jabber_guard_tb_top.sv
// Scoreboard bench: the driver predicts each cycle's outputs and queues
// them; the monitor pops and compares after every rising edge.
module tx_jabber_guard_tb_top;
    localparam int MAXT = 6;
    localparam int UNJ  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic tx_active = 1'b0;
    logic tx_allow, lpbk_allow, col_req, jabbering;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic  jab;
        string tag;
    } exp_t;
    exp_t q[$];

    // Reference model, written from the requirements:
    // m_st 0 idle, 1 transmitting, 2 jabbing, 3 waiting to unjab.
    int m_st  = 0;
    int m_cnt = 0;

    tx_jabber_guard #(.MAX_XMIT_TICKS(MAXT), .UNJAB_TICKS(UNJ)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_active(tx_active),
        .tx_allow(tx_allow), .lpbk_allow(lpbk_allow),
        .col_req(col_req), .jabbering(jabbering)
    );

    always #2.5 clk = ~clk;

    // Compare the four outputs against one expected jabbing flag.
    task automatic cmp(input logic jb, input string tag);
        checks++;
        if (tx_allow !== !jb || lpbk_allow !== !jb || col_req !== jb || jabbering !== jb) begin
            errors++;
            $display("FAIL %s: tx=%b lp=%b col=%b jab=%b expected tx=%b lp=%b col=%b jab=%b",
                     tag, tx_allow, lpbk_allow, col_req, jabbering, !jb, !jb, jb, jb);
        end
    endtask

    // Drive n cycles; tick high every per-th cycle (per 0 means never).
    task automatic drive(input logic txa, input int per, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic tk;
            exp_t e;
            @(negedge clk);
            tk = (per != 0) && (i % per == 0);
            tx_active = txa;
            tick = tk;
            case (m_st)
                0: if (txa) begin m_st = 1; m_cnt = 0; end
                1: if (!txa) m_st = 0;
                   else if (m_cnt >= MAXT) m_st = 2;
                   else if (tk) m_cnt++;
                2: if (!txa) begin m_st = 3; m_cnt = 0; end
                default: if (txa) m_st = 2;
                   else if (m_cnt >= UNJ) m_st = 0;
                   else if (tk) m_cnt++;
            endcase
            e.jab = (m_st >= 2);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Monitor: sample just after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.jab, e.tag);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp(1'b0, "R1 reset");
        rst_n = 1'b1;
        drive(1'b0, 1, 3, "R1 idle");
        drive(1'b1, 1, 4, "R2 short tx");
        drive(1'b0, 1, 3, "R2 back to idle");
        drive(1'b1, 0, 30, "R3 no ticks");
        drive(1'b0, 1, 2, "R3 end");
        drive(1'b1, 1, MAXT + 1, "R2 boundary tx");
        drive(1'b0, 1, 3, "R2 boundary release");
        drive(1'b1, 1, 20, "R4 R5 long tx");
        drive(1'b0, 1, 2, "R6 unjab wait");
        drive(1'b1, 1, 2, "R7 re-jab");
        drive(1'b0, 1, 3, "R7 partial window");
        drive(1'b1, 1, 1, "R7 re-jab again");
        drive(1'b0, 1, 10, "R8 unjab expiry");
        drive(1'b1, 1, 5, "R8 fresh timer");
        drive(1'b0, 1, 2, "R8 idle");
        drive(1'b1, 3, 30, "R3 sparse ticks");
        drive(1'b0, 3, 20, "R8 sparse release");
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule